// File: doc/BRIEF.md
# Table-Driven Power Sequence Engine

This block steps through a table of power-sequence entries and carries each one out against a simple byte-wide register bus. A table entry names an operation, a target block, a register offset, a bit mask, a value, and three condition masks. The condition masks say which silicon revisions, foundries and host interfaces the entry applies to. The engine compares them against the identifiers it is configured with, and it passes over any entry that does not apply. The table sits outside the block, in a ROM or register array. The engine presents an entry index and reads the entry back in the same cycle.

Five operations are supported. A masked read captures a register's masked contents into a status output. A masked read-modify-write changes only the bits selected by the mask. A masked poll reads a register again and again until it matches, and gives up after a bounded number of attempts. A delay waits a number of microseconds or milliseconds. An end marker finishes the sequence. Software or a power controller pulses start and then watches busy, done and error.

Top module: `pseq_engine`

## Requirements
- R1: While idle, a start pulse begins execution at entry 0 and holds busy_o high until an end entry is reached or an error occurs. A start pulse while busy has no effect.
- R2: An entry is executed only if cut mask bit cut_i, fab mask bit fab_i and interface mask bit intf_i are all set. Otherwise the engine moves to the next entry with no bus read or write. The entry layout is offset [55:40], cut mask [39:32], fab mask [31:28], interface mask [27:24], base [23:20], command [19:16], mask [15:8] and value [7:0].
- R3: Command 0 (read) performs one bus read and loads rd_stat_o with read data AND mask. It makes no write.
- R4: Command 1 (write) reads the register and then writes it back. Bits set in the mask take the value bits, and all other bits keep the value that was read.
- R5: Command 2 (poll) reads repeatedly until (data AND mask) equals (value AND mask), and then continues with the next entry.
- R6: A poll that fails to match on POLL_TRIES consecutive reads sets err_o, clears busy_o, gives no done pulse and executes no later entry.
- R7: Command 3 (delay) with value bit 0 clear waits offset × CYC_PER_US clock cycles before the next entry.
- R8: Command 3 with value bit 0 set waits offset × US_PER_MS × CYC_PER_US clock cycles.
- R9: Command 4 (end) ends the sequence whatever its condition masks hold. done_o is high for exactly one cycle and busy_o falls in the same cycle.
- R10: Command codes 5 to 15 are passed over with no bus access.
- R11: err_o stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| cut_i | input | 3 | Silicon revision index (0 = test chip, 1..7 = revisions) |
| fab_i | input | 2 | Foundry index |
| intf_i | input | 2 | Host interface index (0 SDIO, 1 USB, 2 PCIe) |
| tbl_addr_o | output | IDX_W | Index of the current table entry |
| tbl_entry_i | input | 56 | Table entry at tbl_addr_o |
| bus_rd_o | output | 1 | Register read strobe; data returns on bus_rdata_i one cycle later |
| bus_wr_o | output | 1 | Register write strobe |
| bus_base_o | output | 4 | Target block (0 MAC, 1 USB, 2 PCIe, 3 SDIO) |
| bus_addr_o | output | 16 | Register offset |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data |
| rd_stat_o | output | 8 | Masked result of the last read command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when an end entry is reached |
| err_o | output | 1 | Sticky poll-timeout flag |

## Verification
The bench builds the engine with CYC_PER_US = 4, POLL_TRIES = 8 and a 16-entry table. With these values, microsecond delays of a few units, a full two-millisecond delay of 8000 cycles, and exhaustion of the poll limit can all be timed to the cycle window in a short run. The small poll limit also lets the bench count every read of a poll that never matches and confirm that the limit is exact.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam logic [3:0] CMD_RD   = 4'd0;
  localparam logic [3:0] CMD_WR   = 4'd1;
  localparam logic [3:0] CMD_POLL = 4'd2;
  localparam logic [3:0] CMD_DLY  = 4'd3;
  localparam logic [3:0] CMD_END  = 4'd4;

  typedef struct packed {
    logic [15:0] offset;
    logic [7:0]  cut_msk;
    logic [3:0]  fab_msk;
    logic [3:0]  intf_msk;
    logic [3:0]  base;
    logic [3:0]  cmd;
    logic [7:0]  msk;
    logic [7:0]  val;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_REQ, S_RESP, S_WR, S_DLY
  } state_e;
endpackage

// File: rtl/pseq_cond.sv
module pseq_cond (
  input  logic [7:0] cut_msk_i,
  input  logic [3:0] fab_msk_i,
  input  logic [3:0] intf_msk_i,
  input  logic [2:0] cut_i,
  input  logic [1:0] fab_i,
  input  logic [1:0] intf_i,
  output logic       hit_o
);
  assign hit_o = cut_msk_i[cut_i] & fab_msk_i[fab_i] & intf_msk_i[intf_i];
endmodule

// File: rtl/pseq_delay.sv
module pseq_delay #(
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] cnt_i,
  input  logic        ms_i,
  output logic        expire_o
);
  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam int SUB_W = $clog2(US_PER_MS + 1);

  logic [PRE_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic [15:0]      rem_q;
  logic             ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
      rem_q <= '0;
      ms_q  <= 1'b0;
    end else if (load_i) begin
      pre_q <= '0;
      sub_q <= '0;
      rem_q <= cnt_i;
      ms_q  <= ms_i;
    end else if (rem_q != '0) begin
      if (pre_q == PRE_W'(CYC_PER_US - 1)) begin
        pre_q <= '0;
        if (!ms_q) begin
          rem_q <= rem_q - 16'd1;
        end else if (sub_q == SUB_W'(US_PER_MS - 1)) begin
          sub_q <= '0;
          rem_q <= rem_q - 16'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expire_o = (rem_q == '0);
endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pseq_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int CYC_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int POLL_TRIES = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         cut_i,
  input  logic [1:0]         fab_i,
  input  logic [1:0]         intf_i,
  output logic [IDX_W-1:0]   tbl_addr_o,
  input  logic [ENTRY_W-1:0] tbl_entry_i,
  output logic               bus_rd_o,
  output logic               bus_wr_o,
  output logic [3:0]         bus_base_o,
  output logic [15:0]        bus_addr_o,
  output logic [7:0]         bus_wdata_o,
  input  logic [7:0]         bus_rdata_i,
  output logic [7:0]         rd_stat_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int TRY_W = $clog2(POLL_TRIES + 1);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       cmd_q, base_q;
  logic [15:0]      off_q;
  logic [7:0]       msk_q, val_q, wdat_q, stat_q;
  logic [TRY_W-1:0] tries_q;
  logic             done_q, err_q;

  entry_t ent;
  logic   hit, dly_load, dly_exp, poll_ok;

  assign ent = entry_t'(tbl_entry_i);

  pseq_cond u_cond (
    .cut_msk_i (ent.cut_msk),
    .fab_msk_i (ent.fab_msk),
    .intf_msk_i(ent.intf_msk),
    .cut_i     (cut_i),
    .fab_i     (fab_i),
    .intf_i    (intf_i),
    .hit_o     (hit)
  );

  assign dly_load = (state_q == S_FETCH) && hit && (ent.cmd == CMD_DLY);

  pseq_delay #(
    .CYC_PER_US(CYC_PER_US),
    .US_PER_MS (US_PER_MS)
  ) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dly_load),
    .cnt_i   (ent.offset),
    .ms_i    (ent.val[0]),
    .expire_o(dly_exp)
  );

  assign poll_ok = ((bus_rdata_i ^ val_q) & msk_q) == 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      base_q  <= '0;
      off_q   <= '0;
      msk_q   <= '0;
      val_q   <= '0;
      wdat_q  <= '0;
      stat_q  <= '0;
      tries_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            idx_q   <= '0;
            err_q   <= 1'b0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          cmd_q  <= ent.cmd;
          base_q <= ent.base;
          off_q  <= ent.offset;
          msk_q  <= ent.msk;
          val_q  <= ent.val;
          if (ent.cmd == CMD_END) begin
            // end is honoured whatever its masks
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (!hit || ent.cmd > CMD_END) begin
            idx_q <= idx_q + 1'b1;
          end else if (ent.cmd == CMD_DLY) begin
            state_q <= S_DLY;
          end else begin
            tries_q <= '0;
            state_q <= S_REQ;
          end
        end
        S_REQ: state_q <= S_RESP;
        S_RESP: begin
          if (cmd_q == CMD_RD) begin
            stat_q  <= bus_rdata_i & msk_q;
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FETCH;
          end else if (cmd_q == CMD_WR) begin
            wdat_q  <= (bus_rdata_i & ~msk_q) | (val_q & msk_q);
            state_q <= S_WR;
          end else if (poll_ok) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FETCH;
          end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= S_REQ;
          end
        end
        S_WR: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= S_FETCH;
        end
        S_DLY: begin
          if (dly_exp) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tbl_addr_o  = idx_q;
  assign bus_rd_o    = (state_q == S_REQ);
  assign bus_wr_o    = (state_q == S_WR);
  assign bus_base_o  = base_q;
  assign bus_addr_o  = off_q;
  assign bus_wdata_o = wdat_q;
  assign rd_stat_o   = stat_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bus_rd_o,
  input logic bus_wr_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_rd_wr_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bus_rd_o || bus_wr_o));

  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_wr_after_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> $past(bus_rd_o, 2));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o));

  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  assert_err_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> !err_o);
endmodule

bind pseq_engine pseq_chk u_chk (
  .clk_i, .rst_ni, .start_i, .bus_rd_o, .bus_wr_o, .busy_o, .done_o, .err_o
);

// File: tb/sim_pseq_engine.sv
module sim_pseq_engine;
  localparam int IDX_W = 4;
  localparam int CPU   = 4;
  localparam int TRIES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cut = 3'd0;
  logic [1:0]  fab = 2'd0;
  logic [1:0]  intf = 2'd0;
  logic [IDX_W-1:0] tbl_addr;
  logic [55:0] tbl [16];
  logic [55:0] tbl_ent;
  logic        rd, wr, busy, done, err;
  logic [3:0]  base;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata, stat;
  logic [7:0]  poll_reg = 8'h00;
  logic [7:0]  mem [4][16];
  logic        mem_rst = 1'b0, clr = 1'b0;
  int          cyc = 0, rd_cnt, wr_cnt, done_cnt, st_cyc, wr_cyc;
  logic [7:0]  last_wd;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign tbl_ent = tbl[tbl_addr];

  pseq_engine #(.IDX_W(IDX_W), .CYC_PER_US(CPU), .US_PER_MS(1000), .POLL_TRIES(TRIES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cut_i(cut), .fab_i(fab), .intf_i(intf),
    .tbl_addr_o(tbl_addr), .tbl_entry_i(tbl_ent), .bus_rd_o(rd), .bus_wr_o(wr),
    .bus_base_o(base), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .rd_stat_o(stat), .busy_o(busy), .done_o(done), .err_o(err)
  );

  function automatic logic [7:0] ini(int b, int o);
    return 8'h5A ^ 8'((b << 4) | o);
  endfunction

  // register file with one-cycle read latency; address 0/15 is the poll target
  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rst) begin
      for (int b = 0; b < 4; b++)
        for (int o = 0; o < 16; o++) mem[b][o] <= ini(b, o);
    end else if (wr) begin
      mem[base[1:0]][addr[3:0]] <= wdata;
    end
    if (rd) rdata <= (base == 4'd0 && addr[3:0] == 4'd15) ? poll_reg : mem[base[1:0]][addr[3:0]];
    if (clr) begin
      rd_cnt <= 0; wr_cnt <= 0; done_cnt <= 0; wr_cyc <= 0; last_wd <= 8'h00;
    end else begin
      if (rd) rd_cnt <= rd_cnt + 1;
      if (wr) begin
        wr_cnt <= wr_cnt + 1;
        last_wd <= wdata;
        if (wr_cnt == 0) wr_cyc <= cyc;
      end
      if (done) done_cnt <= done_cnt + 1;
    end
    if (start && !busy) st_cyc <= cyc;
  end

  function automatic logic [55:0] mk(logic [3:0] cmd, logic [3:0] b, logic [15:0] off,
                                     logic [7:0] m, logic [7:0] v, logic [7:0] cm = 8'hFF,
                                     logic [3:0] fm = 4'hF, logic [3:0] im = 4'hF);
    return {off, cm, fm, im, b, cmd, m, v};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 16; i++) tbl[i] = mk(4'd4, 4'd0, 16'd0, 8'h00, 8'h00);
    @(negedge clk) begin mem_rst = 1'b1; clr = 1'b1; end
    @(negedge clk) begin mem_rst = 1'b0; clr = 1'b0; end
  endtask

  task automatic run(int lim);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < lim && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
    chk(stat == 8'h00, "R3 reset status", stat, 0);
  endtask

  task automatic t_read();
    clear_tbl();
    tbl[0] = mk(4'd0, 4'd1, 16'd3, 8'h0F, 8'h00);
    run(100);
    chk(stat == (ini(1, 3) & 8'h0F), "R3 masked read", stat, ini(1, 3) & 8'h0F);
    chk(rd_cnt == 1 && wr_cnt == 0, "R3 one read no write", rd_cnt * 10 + wr_cnt, 10);
    chk(done_cnt == 1 && !busy, "R9 done once", done_cnt, 1);
  endtask

  task automatic t_write();
    logic [7:0] e;
    clear_tbl();
    e = (ini(2, 5) & 8'h0F) | (8'h3C & 8'hF0);
    tbl[0] = mk(4'd1, 4'd2, 16'd5, 8'hF0, 8'h3C);
    tbl[1] = mk(4'd0, 4'd2, 16'd5, 8'hFF, 8'h00);
    run(100);
    chk(last_wd == e, "R4 rmw data", last_wd, e);
    chk(stat == e, "R4 read back", stat, e);
    chk(wr_cnt == 1, "R4 one write", wr_cnt, 1);
  endtask

  task automatic t_skip();
    clear_tbl();
    cut = 3'd2; fab = 2'd1; intf = 2'd1;
    tbl[0] = mk(4'd1, 4'd0, 16'd1, 8'hFF, 8'h11, 8'hFB);
    tbl[1] = mk(4'd1, 4'd0, 16'd2, 8'hFF, 8'h22, 8'hFF, 4'hD);
    tbl[2] = mk(4'd1, 4'd0, 16'd3, 8'hFF, 8'h33, 8'hFF, 4'hF, 4'hD);
    tbl[3] = mk(4'd0, 4'd3, 16'd7, 8'hFF, 8'h00, 8'h04, 4'h2, 4'h2);
    run(100);
    chk(wr_cnt == 0, "R2 mismatched entries skipped", wr_cnt, 0);
    chk(rd_cnt == 1 && stat == ini(3, 7), "R2 matching entry runs", stat, ini(3, 7));
    cut = 3'd0; fab = 2'd0; intf = 2'd0;
  endtask

  task automatic t_undef();
    clear_tbl();
    tbl[0] = mk(4'd7, 4'd0, 16'd1, 8'hFF, 8'h00);
    tbl[1] = mk(4'd15, 4'd1, 16'd2, 8'hFF, 8'h00);
    run(100);
    chk(rd_cnt == 0 && wr_cnt == 0, "R10 undefined codes no access", rd_cnt + wr_cnt, 0);
    chk(done_cnt == 1, "R10 sequence completes", done_cnt, 1);
  endtask

  task automatic t_poll_ok();
    clear_tbl();
    poll_reg = 8'h00;
    tbl[0] = mk(4'd2, 4'd0, 16'd15, 8'h80, 8'h80);
    tbl[1] = mk(4'd0, 4'd1, 16'd1, 8'hFF, 8'h00);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    poll_reg = 8'h93;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(!err && done_cnt == 1, "R5 poll matched", err, 0);
    chk(rd_cnt >= 3 && rd_cnt < TRIES + 1, "R5 polled more than once", rd_cnt, 3);
    chk(stat == ini(1, 1), "R5 next entry ran", stat, ini(1, 1));
  endtask

  task automatic t_poll_to();
    clear_tbl();
    poll_reg = 8'h7F;
    tbl[0] = mk(4'd2, 4'd0, 16'd15, 8'h80, 8'h80);
    tbl[1] = mk(4'd1, 4'd0, 16'd2, 8'hFF, 8'hAA);
    run(200);
    chk(err == 1'b1 && !busy, "R6 timeout error", err, 1);
    chk(rd_cnt == TRIES, "R6 read attempts", rd_cnt, TRIES);
    chk(wr_cnt == 0 && done_cnt == 0, "R6 sequence stopped", wr_cnt + done_cnt, 0);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R11 error sticky", err, 1);
    clear_tbl();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(err == 1'b0, "R11 cleared by start", err, 0);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic t_delay(bit ms, int n, string req);
    int lo;
    clear_tbl();
    lo = ms ? n * 1000 * CPU : n * CPU;
    tbl[0] = mk(4'd3, 4'd0, 16'(n), 8'h00, {7'd0, ms});
    tbl[1] = mk(4'd1, 4'd1, 16'd4, 8'hFF, 8'h55);
    run(lo + 200);
    chk(wr_cnt == 1 && (wr_cyc - st_cyc) >= lo && (wr_cyc - st_cyc) <= lo + 12,
        req, wr_cyc - st_cyc, lo);
  endtask

  task automatic t_start_busy();
    clear_tbl();
    tbl[0] = mk(4'd1, 4'd1, 16'd6, 8'h0F, 8'h05);
    tbl[1] = mk(4'd3, 4'd0, 16'd5, 8'h00, 8'h00);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (8) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(wr_cnt == 1 && done_cnt == 1, "R1 start while busy ignored", wr_cnt, 1);
  endtask

  task automatic t_end_masked();
    clear_tbl();
    tbl[0] = mk(4'd4, 4'd0, 16'd0, 8'h00, 8'h00, 8'h00, 4'h0, 4'h0);
    tbl[1] = mk(4'd1, 4'd0, 16'd1, 8'hFF, 8'h12);
    run(50);
    chk(done_cnt == 1 && wr_cnt == 0 && !busy, "R9 end ignores masks", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) tbl[i] = 56'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_skip();
    t_undef();
    t_poll_ok();
    t_poll_to();
    t_delay(1'b0, 5, "R7 microsecond delay");
    t_delay(1'b1, 2, "R8 millisecond delay");
    t_start_busy();
    t_end_masked();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule